// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block takes a DDR3 memory device from power-on to an idle state in which it can accept normal traffic. After its own reset is released it holds the device in reset. It then holds clock-enable low and waits out the settling time. Next it programs the four mode registers with values supplied as parameters, and it starts a long ZQ calibration. When all of this is complete it raises a done flag. Every wait is counted in clock cycles by one shared down-counter, which is reloaded each time the sequencer enters a new step.

The block has no data-flow interface. All of its pins are plain control levels. A memory controller holds off its own scheduler until `init_done` is high and then takes over the command pins. A design that needs to restart the device asserts `rst` again.

Top module: `ddr3_init_seq`

## Requirements
- R1: In the first RESET_HOLD cycles after `rst` is released, including the cycle right after the last reset edge, `ddr_reset_n` is 0, `ddr_cke` is 0, `ddr_odt` is 0 and the command is NOP. NOP is cs_n=0, ras_n=1, cas_n=1, we_n=1. During these cycles the address and bank outputs are 0.
- R2: For the next CKE_HOLD cycles, `ddr_reset_n` is 1, `ddr_cke` is still 0 and the command is NOP.
- R3: `ddr_cke` then goes to 1 and stays there. The command stays NOP for T_XPR+T_DLLK+T_ZQINIT cycles.
- R4: Each mode register load is an MRS command, with cs_n, ras_n, cas_n and we_n all 0. The loads come in a fixed order: bank 2 with MR2_VAL, bank 3 with MR3_VAL, bank 1 with MR1_VAL, then bank 0 with MR0_VAL and bit 8 (DLL reset) forced to 1. On every cycle that is not MRS or ZQCL, the address and bank are 0.
- R5: The MR2 load is followed by the MR3 load exactly T_MRD cycles later, and the MR3 load by the MR1 load exactly T_MRD cycles later. Only NOPs are issued in between.
- R6: The MR1 load is followed by the MR0 load exactly T_MOD cycles later, and the MR0 load by ZQCL exactly T_MOD cycles later. Only NOPs are issued in between.
- R7: ZQCL has cs_n=0, ras_n=1, cas_n=1, we_n=0, bank 0, and an address with only bit 10 set. `init_done` rises exactly T_ZQINIT cycles after the ZQCL cycle, and only NOPs are issued in between.
- R8: `ddr_odt` is always the inverse of `ddr_we_n`.
- R9: Once `init_done` is 1 it stays 1, with NOP, `ddr_cke`=1 and `ddr_reset_n`=1, until `rst` is asserted.
- R10: `rst` is synchronous and active high. It overrides any step transition due at the same edge, and the outputs return to the R1 state on the next cycle. The whole sequence then restarts from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high restart |
| ddr_reset_n | output | 1 | Device reset, active low |
| ddr_cke | output | 1 | Device clock enable |
| ddr_odt | output | 1 | On-die termination, inverse of write-enable line |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_addr | output | ADDR_W | Address bus, carries mode register values |
| ddr_ba | output | BA_W | Bank address, selects the mode register |
| init_done | output | 1 | High once the whole sequence has finished |

## Verification
Two events can land on the same clock edge: the shared counter reaching zero, which moves the sequencer into the MR2 load, and a restart request. The bench raises `rst` so that it is sampled on the very edge where the counter expires at the end of the settling wait. That edge would otherwise produce the first MRS. The bench then checks that the next cycle shows the device held in reset with a NOP, not an MRS. After that it replays the full expected sequence cycle by cycle through the scoreboard, to show that the restart began from the start.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [3:0] {
    ST_RST, ST_CKE, ST_SETTLE,
    ST_MR2, ST_GAP2, ST_MR3, ST_GAP3,
    ST_MR1, ST_GAP1, ST_MR0, ST_GAP0,
    ST_ZQ, ST_GAPZ, ST_DONE
  } seq_state_t;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_MRS = 4'b0000;
  localparam logic [3:0] CMD_ZQC = 4'b0110;

  function automatic seq_state_t step_after(input seq_state_t s);
    case (s)
      ST_RST:    step_after = ST_CKE;
      ST_CKE:    step_after = ST_SETTLE;
      ST_SETTLE: step_after = ST_MR2;
      ST_MR2:    step_after = ST_GAP2;
      ST_GAP2:   step_after = ST_MR3;
      ST_MR3:    step_after = ST_GAP3;
      ST_GAP3:   step_after = ST_MR1;
      ST_MR1:    step_after = ST_GAP1;
      ST_GAP1:   step_after = ST_MR0;
      ST_MR0:    step_after = ST_GAP0;
      ST_GAP0:   step_after = ST_ZQ;
      ST_ZQ:     step_after = ST_GAPZ;
      default:   step_after = ST_DONE;
    endcase
  endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/ddr_init_fsm.sv
module ddr_init_fsm
  import ddr_init_pkg::*;
#(
  parameter int CNT_W      = 17,
  parameter int RESET_HOLD = 40000,
  parameter int CKE_HOLD   = 100000,
  parameter int SETTLE     = 1058,
  parameter int T_MRD      = 4,
  parameter int T_MOD      = 12,
  parameter int T_ZQINIT   = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             expired,
  output seq_state_t       state,
  output logic             load,
  output logic [CNT_W-1:0] load_val
);
  seq_state_t next_state;
  logic       advance;

  // cycles spent in a step, minus one
  function automatic logic [CNT_W-1:0] span(input seq_state_t s);
    case (s)
      ST_RST:             span = CNT_W'(RESET_HOLD - 1);
      ST_CKE:             span = CNT_W'(CKE_HOLD - 1);
      ST_SETTLE:          span = CNT_W'(SETTLE - 1);
      ST_GAP2, ST_GAP3:   span = CNT_W'(T_MRD - 2);
      ST_GAP1, ST_GAP0:   span = CNT_W'(T_MOD - 2);
      ST_GAPZ:            span = CNT_W'(T_ZQINIT - 2);
      default:            span = '0;
    endcase
  endfunction

  always_comb begin
    advance    = expired && (state != ST_DONE);
    next_state = step_after(state);
    load       = rst || advance;
    load_val   = rst ? span(ST_RST) : span(next_state);
  end

  always_ff @(posedge clk) begin
    if (rst)
      state <= ST_RST;
    else if (advance)
      state <= next_state;
  end
endmodule

// File: rtl/ddr_init_cmdgen.sv
module ddr_init_cmdgen
  import ddr_init_pkg::*;
#(
  parameter int              ADDR_W  = 14,
  parameter int              BA_W    = 3,
  parameter logic [ADDR_W-1:0] MR0_VAL = '0,
  parameter logic [ADDR_W-1:0] MR1_VAL = '0,
  parameter logic [ADDR_W-1:0] MR2_VAL = '0,
  parameter logic [ADDR_W-1:0] MR3_VAL = '0
) (
  input  seq_state_t        state,
  output logic              ddr_reset_n,
  output logic              ddr_cke,
  output logic [3:0]        cmd,
  output logic [ADDR_W-1:0] ddr_addr,
  output logic [BA_W-1:0]   ddr_ba,
  output logic              init_done
);
  localparam logic [ADDR_W-1:0] DLL_RST = ADDR_W'(1) << 8;
  localparam logic [ADDR_W-1:0] ZQ_LONG = ADDR_W'(1) << 10;

  always_comb begin
    ddr_reset_n = (state != ST_RST);
    ddr_cke     = (state != ST_RST) && (state != ST_CKE);
    init_done   = (state == ST_DONE);
    cmd         = CMD_NOP;
    ddr_addr    = '0;
    ddr_ba      = '0;
    case (state)
      ST_MR2: begin cmd = CMD_MRS; ddr_ba = BA_W'(2); ddr_addr = MR2_VAL; end
      ST_MR3: begin cmd = CMD_MRS; ddr_ba = BA_W'(3); ddr_addr = MR3_VAL; end
      ST_MR1: begin cmd = CMD_MRS; ddr_ba = BA_W'(1); ddr_addr = MR1_VAL; end
      ST_MR0: begin cmd = CMD_MRS; ddr_ba = BA_W'(0); ddr_addr = MR0_VAL | DLL_RST; end
      ST_ZQ:  begin cmd = CMD_ZQC; ddr_addr = ZQ_LONG; end
      default: ;
    endcase
  end
endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
  import ddr_init_pkg::*;
#(
  parameter int                ADDR_W     = 14,
  parameter int                BA_W       = 3,
  parameter int                RESET_HOLD = 40000,
  parameter int                CKE_HOLD   = 100000,
  parameter int                T_XPR      = 34,
  parameter int                T_DLLK     = 512,
  parameter int                T_ZQINIT   = 512,
  parameter int                T_MRD      = 4,
  parameter int                T_MOD      = 12,
  parameter logic [ADDR_W-1:0] MR0_VAL    = 14'h0420,
  parameter logic [ADDR_W-1:0] MR1_VAL    = 14'h0044,
  parameter logic [ADDR_W-1:0] MR2_VAL    = 14'h0008,
  parameter logic [ADDR_W-1:0] MR3_VAL    = 14'h0000
) (
  input  logic              clk,
  input  logic              rst,
  output logic              ddr_reset_n,
  output logic              ddr_cke,
  output logic              ddr_odt,
  output logic              ddr_cs_n,
  output logic              ddr_ras_n,
  output logic              ddr_cas_n,
  output logic              ddr_we_n,
  output logic [ADDR_W-1:0] ddr_addr,
  output logic [BA_W-1:0]   ddr_ba,
  output logic              init_done
);
  localparam int SETTLE = T_XPR + T_DLLK + T_ZQINIT;
  localparam int M1     = (RESET_HOLD > CKE_HOLD) ? RESET_HOLD : CKE_HOLD;
  localparam int M2     = (SETTLE > T_ZQINIT) ? SETTLE : T_ZQINIT;
  localparam int M3     = (M1 > M2) ? M1 : M2;
  localparam int MAXD   = (M3 > T_MOD) ? M3 : T_MOD;
  localparam int CNT_W  = (MAXD > 2) ? $clog2(MAXD) : 1;

  seq_state_t       state;
  logic             expired;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic [3:0]       cmd;

  ddr_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .load(load), .load_val(load_val), .expired(expired)
  );

  ddr_init_fsm #(
    .CNT_W(CNT_W), .RESET_HOLD(RESET_HOLD), .CKE_HOLD(CKE_HOLD),
    .SETTLE(SETTLE), .T_MRD(T_MRD), .T_MOD(T_MOD), .T_ZQINIT(T_ZQINIT)
  ) u_fsm (
    .clk(clk), .rst(rst), .expired(expired),
    .state(state), .load(load), .load_val(load_val)
  );

  ddr_init_cmdgen #(
    .ADDR_W(ADDR_W), .BA_W(BA_W),
    .MR0_VAL(MR0_VAL), .MR1_VAL(MR1_VAL), .MR2_VAL(MR2_VAL), .MR3_VAL(MR3_VAL)
  ) u_cmd (
    .state(state), .ddr_reset_n(ddr_reset_n), .ddr_cke(ddr_cke), .cmd(cmd),
    .ddr_addr(ddr_addr), .ddr_ba(ddr_ba), .init_done(init_done)
  );

  assign {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} = cmd;
  assign ddr_odt = ~cmd[0];
endmodule

// File: rtl/ddr3_init_seq_chk.sv
module ddr3_init_seq_chk #(
  parameter int T_MRD = 4
) (
  input logic clk,
  input logic rst,
  input logic ddr_reset_n,
  input logic ddr_cke,
  input logic ddr_odt,
  input logic ddr_cs_n,
  input logic ddr_ras_n,
  input logic ddr_cas_n,
  input logic ddr_we_n,
  input logic init_done
);
  logic [3:0] cmd;
  logic [7:0] gap;
  assign cmd = {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n};

  // cycles since the last non-NOP command, saturating
  always_ff @(posedge clk) begin
    if (rst)
      gap <= 8'hFF;
    else if (cmd != 4'b0111)
      gap <= 8'd1;
    else if (gap != 8'hFF)
      gap <= gap + 8'd1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !ddr_reset_n |-> (!ddr_cke && !ddr_odt && cmd == 4'b0111));

  p_reset_n_holds_r2: assert property (@(posedge clk) disable iff (rst)
    ddr_reset_n |=> ddr_reset_n);

  p_cke_holds_r3: assert property (@(posedge clk) disable iff (rst)
    ddr_cke |=> ddr_cke);

  p_cmd_needs_cke_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd != 4'b0111) |-> (ddr_cke && ddr_reset_n));

  p_mrs_spacing_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0000) |-> (gap >= 8'(T_MRD)));

  p_mrs_then_nop_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0000) |=> (cmd == 4'b0111));

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (cmd == 4'b0111 && ddr_cke && ddr_reset_n));

  p_odt_low_on_nop_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0111) |-> !ddr_odt);
endmodule

bind ddr3_init_seq ddr3_init_seq_chk #(.T_MRD(T_MRD)) u_chk (
  .clk(clk), .rst(rst), .ddr_reset_n(ddr_reset_n), .ddr_cke(ddr_cke),
  .ddr_odt(ddr_odt), .ddr_cs_n(ddr_cs_n), .ddr_ras_n(ddr_ras_n),
  .ddr_cas_n(ddr_cas_n), .ddr_we_n(ddr_we_n), .init_done(init_done)
);

// File: tb/ddr3_init_seq_test.sv
module ddr3_init_seq_test;
  localparam int RH = 20, CH = 30, XPR = 6, DLLK = 10, ZQI = 16, MRD = 4, MOD = 12;
  localparam logic [13:0] V0 = 14'h0420, V1 = 14'h0044, V2 = 14'h0208, V3 = 14'h0004;
  localparam int B0  = RH;
  localparam int B1  = B0 + CH;
  localparam int P2  = B1 + XPR + DLLK + ZQI;
  localparam int P3  = P2 + MRD;
  localparam int P1  = P3 + MRD;
  localparam int P0  = P1 + MOD;
  localparam int PZ  = P0 + MOD;
  localparam int PD  = PZ + ZQI;

  typedef struct packed {
    logic rn, cke, odt, cs, ras, cas, we;
    logic [2:0] ba;
    logic [13:0] addr;
    logic done;
  } obs_t;

  logic clk = 0, rst = 1;
  logic ddr_reset_n, ddr_cke, ddr_odt, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n, init_done;
  logic [13:0] ddr_addr;
  logic [2:0]  ddr_ba;

  int n_cmp = 0, n_bad = 0, idx = 0;
  logic mon_on = 0;
  obs_t exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  ddr3_init_seq #(
    .RESET_HOLD(RH), .CKE_HOLD(CH), .T_XPR(XPR), .T_DLLK(DLLK), .T_ZQINIT(ZQI),
    .T_MRD(MRD), .T_MOD(MOD), .MR0_VAL(V0), .MR1_VAL(V1), .MR2_VAL(V2), .MR3_VAL(V3)
  ) uut (
    .clk(clk), .rst(rst), .ddr_reset_n(ddr_reset_n), .ddr_cke(ddr_cke), .ddr_odt(ddr_odt),
    .ddr_cs_n(ddr_cs_n), .ddr_ras_n(ddr_ras_n), .ddr_cas_n(ddr_cas_n), .ddr_we_n(ddr_we_n),
    .ddr_addr(ddr_addr), .ddr_ba(ddr_ba), .init_done(init_done)
  );

  function automatic obs_t observed();
    return '{ddr_reset_n, ddr_cke, ddr_odt, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n,
             ddr_ba, ddr_addr, init_done};
  endfunction

  function automatic obs_t nop_item(input logic rn, input logic cke, input logic dn);
    return '{rn, cke, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 14'd0, dn};
  endfunction

  // expected pins in cycle c after reset release
  function automatic obs_t expect_at(input int c);
    obs_t e;
    e = nop_item(c >= B0, c >= B1, c >= PD);
    if (c == P2) begin e.cs = 0; e.ras = 0; e.cas = 0; e.we = 0; e.ba = 3'd2; e.addr = V2; end
    if (c == P3) begin e.cs = 0; e.ras = 0; e.cas = 0; e.we = 0; e.ba = 3'd3; e.addr = V3; end
    if (c == P1) begin e.cs = 0; e.ras = 0; e.cas = 0; e.we = 0; e.ba = 3'd1; e.addr = V1; end
    if (c == P0) begin e.cs = 0; e.ras = 0; e.cas = 0; e.we = 0; e.ba = 3'd0; e.addr = V0 | 14'h0100; end
    if (c == PZ) begin e.cs = 0; e.we = 0; e.addr = 14'h0400; end
    e.odt = ~e.we;
    return e;
  endfunction

  function automatic string tag_at(input int c);
    if (c < B0) return "R1";
    if (c < B1) return "R2";
    if (c < P2) return "R3";
    if (c == P2) return "R4";
    if (c < P1) return "R5";
    if (c < PZ) return "R6";
    if (c < PD) return "R7";
    return "R9";
  endfunction

  task automatic push_run(input int n);
    for (int c = 0; c < n; c++) begin
      exp_q.push_back(expect_at(c));
      tag_q.push_back(tag_at(c));
    end
    idx = 0;
  endtask

  task automatic check(input string tag, input obs_t got, input obs_t exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: pops one expected item per cycle
  always @(negedge clk) begin
    #1;
    if (mon_on && exp_q.size() > 0) begin
      obs_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, observed(), e);
      // R8: odt is the inverse of we_n on every cycle
      check("R8", {31'd0, ddr_odt}, {31'd0, ~ddr_we_n});
      idx++;
    end
  end

  initial begin
    #(200000 * 20);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R1", observed(), nop_item(0, 0, 0));

    // full run 1
    @(negedge clk);
    push_run(PD + 6);
    rst = 0; mon_on = 1;
    wait (exp_q.size() == 0);
    mon_on = 0;

    // R10: reset during done
    @(negedge clk); rst = 1;
    @(negedge clk); #1 check("R10", observed(), nop_item(0, 0, 0));

    // R10: reset on the edge where MR2 would be issued
    @(negedge clk); rst = 0;
    repeat (P2 - 1) @(negedge clk);
    #1 check("R3", observed(), nop_item(1, 1, 0));
    rst = 1;
    @(negedge clk); #1 check("R10", observed(), nop_item(0, 0, 0));

    // full run 2 after the collision
    @(negedge clk);
    push_run(PD + 4);
    rst = 0; mon_on = 1;
    wait (exp_q.size() == 0);
    mon_on = 0;

    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule